// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block holds every register that software programs in a four-channel DMA controller. Software reaches it over an 8-bit data bus with a 4-bit register offset. Each channel has a 16-bit start address, a 16-bit transfer count and a mode byte. The address and the count each keep a base copy and a working copy. Shared registers hold a command byte, a per-channel mask, a per-channel software request, a status byte and a holding byte.

A 16-bit value is loaded as two byte writes. A single byte-pointer flip-flop decides whether each byte goes to the low half or the high half. Some offsets act on one channel and others act on the whole mask at once. Writing a mode or changing a request also clears status bits.

The outputs feed an arbiter and a transfer engine, which are separate blocks: the global enable, the request vector, the mask vector, the base registers, the mode bytes and the holding byte. The transfer engine reports terminal counts back through a pulse input that sets the low status bits.

Top module: `dmac_regfile`

## Requirements
- R1: After a synchronous active-high reset, the registers are in this state: mask = 4'b1111, request vector = 0, command = 0 (so `ctl_enable` = 1), status = 0, holding byte = 0, byte pointer = 0, and every channel address, count and mode = 0.
- R2: A write to an even offset below 8 loads the address of channel offset/2, and a write to an odd offset below 8 loads its count. The byte goes into both the base and the working register. With pointer = 0 it replaces bits 7:0 and keeps bits 15:8. With pointer = 1 it replaces bits 15:8 and keeps bits 7:0. Channel i occupies bits [16i+15:16i] of the flattened outputs.
- R3: The byte pointer toggles after every address or count write and after every read of offsets 0 to 7. A write to offset 12 clears the pointer and copies the data byte into the holding register.
- R4: A write to offset 8 loads the command byte, and `ctl_enable` is the inverse of command bit 2.
- R5: For a write to offset 9, data bits 1:0 select a channel. If data bit 2 = 1, the request bit of that channel and status bit 4+channel are set. If data bit 2 = 0, both are cleared.
- R6: For a write to offset 10, data bits 1:0 select a channel. Data bit 2 = 1 sets that channel's mask bit and data bit 2 = 0 clears it. No other mask bit changes.
- R7: For a write to offset 11, data bits 1:0 select a channel. The whole data byte becomes that channel's mode (bits [8i+7:8i] of `mode_flat`), and status bit (channel) is cleared.
- R8: A write to offset 13 (master clear) sets all four mask bits, clears the byte pointer, clears status bits 3:0 and clears the holding byte. It leaves the command, the request vector and status bits 7:4 unchanged.
- R9: A write to offset 14 clears all mask bits. A write to offset 15 loads the mask from data bits 3:0.
- R10: A pulse on `tc_set[i]` sets status bit i. A read of offset 8 returns the status byte and then clears bits 3:0. If a pulse and a clear happen in the same cycle, the pulse wins.
- R11: A read of an offset below 8 returns one byte of the working address (even offset) or working count (odd offset) of channel offset/2: the low byte when the pointer = 0 and the high byte when it = 1. A read of offsets 9 to 15 returns 0 and changes nothing. `rd_data` is 0 whenever `rd_en` = 0.
- R12: When `wr_en` and `rd_en` are both high, only the write takes effect. The read side effects are suppressed and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_offset | input | 4 | Register offset |
| wr_data | input | 8 | Write data |
| tc_set | input | 4 | Terminal-count pulses from the transfer engine, one per channel |
| rd_data | output | 8 | Read data, combinational |
| ctl_enable | output | 1 | Global controller enable |
| chan_req | output | 4 | Software request vector |
| chan_mask | output | 4 | Channel mask vector, 1 = masked |
| base_addr_flat | output | 64 | Base addresses, 16 bits per channel |
| base_cnt_flat | output | 64 | Base counts, 16 bits per channel |
| mode_flat | output | 32 | Mode bytes, 8 bits per channel |
| hold_byte | output | 8 | Holding register |

## Verification
Word loads are tried with a plain low-then-high pair and with a channel-3 count pair. These show whether the even/odd offset split and the channel index are right. Runs of three writes to one address, and a run broken by a pointer clear, show whether each write keeps the untouched half and whether the pointer toggles or resets. Reads of the word offsets interleaved with reads of the unused offsets show which accesses advance the pointer. Status-clearing paths are each set up with both halves of the status byte non-zero, which tells a clear of bits 3:0 apart from a clear of the whole byte.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   // Register offsets that carry behaviour (decoded by the register file)
   localparam logic [3:0] OFS_CMD      = 4'd8;
   localparam logic [3:0] OFS_SWREQ    = 4'd9;
   localparam logic [3:0] OFS_ONEMASK  = 4'd10;
   localparam logic [3:0] OFS_MODE     = 4'd11;
   localparam logic [3:0] OFS_PTRCLR   = 4'd12;
   localparam logic [3:0] OFS_MCLR     = 4'd13;
   localparam logic [3:0] OFS_MASKCLR  = 4'd14;
   localparam logic [3:0] OFS_MASKLD   = 4'd15;

   // Data bit that selects set (1) or clear (0) for single-channel ops
   localparam int SETCLR_BIT = 2;
   // Command bit that disables the controller
   localparam int DIS_BIT    = 2;

   typedef struct packed {
      logic word_wr;    // address/count byte write
      logic word_cnt;   // 1 = count, 0 = address
      logic word_rd;    // address/count byte read
      logic stat_rd;    // status read
      logic cmd_wr;
      logic req_wr;
      logic onemask_wr;
      logic mode_wr;
      logic ptr_clr;
      logic mclr;
      logic mask_clr;
      logic mask_ld;
   } dmac_op_t;

   // Replace one byte lane of a two-lane word
   function automatic logic [15:0] merge_lane(input logic [15:0] word,
                                              input logic [7:0]  b,
                                              input logic        hi);
      return hi ? {b, word[7:0]} : {word[15:8], b};
   endfunction

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
   import dmac_pkg::*;
#(
   parameter int OFFS_W = 4,
   parameter int NUM_CH = 4
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [OFFS_W-1:0] reg_offset,
   output dmac_op_t          op
);
   localparam int WORD_REGS = 2 * NUM_CH;

   logic [3:0] ofs;
   logic       rd_ok;
   logic       in_words;

   assign ofs      = reg_offset[3:0];
   assign rd_ok    = rd_en && !wr_en;
   assign in_words = ({28'd0, ofs} < WORD_REGS);

   always_comb begin
      op            = '0;
      op.word_cnt   = ofs[0];
      op.word_wr    = wr_en && in_words;
      op.word_rd    = rd_ok && in_words;
      op.stat_rd    = rd_ok && (ofs == OFS_CMD);
      if (wr_en) begin
         unique case (ofs)
            OFS_CMD:     op.cmd_wr     = 1'b1;
            OFS_SWREQ:   op.req_wr     = 1'b1;
            OFS_ONEMASK: op.onemask_wr = 1'b1;
            OFS_MODE:    op.mode_wr    = 1'b1;
            OFS_PTRCLR:  op.ptr_clr    = 1'b1;
            OFS_MCLR:    op.mclr       = 1'b1;
            OFS_MASKCLR: op.mask_clr   = 1'b1;
            OFS_MASKLD:  op.mask_ld    = 1'b1;
            default:     ;
         endcase
      end
   end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
   import dmac_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_we,
   input  logic              cnt_we,
   input  logic              mode_we,
   input  logic              lane_hi,
   input  logic [DATA_W-1:0] wr_data,
   output logic [WORD_W-1:0] base_addr,
   output logic [WORD_W-1:0] cur_addr,
   output logic [WORD_W-1:0] base_cnt,
   output logic [WORD_W-1:0] cur_cnt,
   output logic [DATA_W-1:0] mode
);
   always_ff @(posedge clk) begin
      if (rst) begin
         base_addr <= '0;
         cur_addr  <= '0;
         base_cnt  <= '0;
         cur_cnt   <= '0;
         mode      <= '0;
      end else begin
         if (addr_we) begin
            base_addr <= merge_lane(base_addr, wr_data, lane_hi);
            cur_addr  <= merge_lane(cur_addr,  wr_data, lane_hi);
         end
         if (cnt_we) begin
            base_cnt  <= merge_lane(base_cnt, wr_data, lane_hi);
            cur_cnt   <= merge_lane(cur_cnt,  wr_data, lane_hi);
         end
         if (mode_we)
            mode <= wr_data;
      end
   end
endmodule

// File: rtl/dmac_global_regs.sv
module dmac_global_regs
   import dmac_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NUM_CH = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  dmac_op_t            op,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [NUM_CH-1:0]   tc_set,
   output logic [DATA_W-1:0]   command,
   output logic [NUM_CH-1:0]   mask,
   output logic [NUM_CH-1:0]   req,
   output logic [2*NUM_CH-1:0] status,
   output logic [DATA_W-1:0]   temp,
   output logic                ptr
);
   localparam int CH_W = $clog2(NUM_CH);

   logic [CH_W-1:0]     sel;
   logic                setv;
   logic [2*NUM_CH-1:0] status_nxt;
   logic [NUM_CH-1:0]   mask_nxt;
   logic [NUM_CH-1:0]   req_nxt;
   logic                ptr_nxt;

   assign sel  = wr_data[CH_W-1:0];
   assign setv = wr_data[SETCLR_BIT];

   always_comb begin
      status_nxt = status;
      if (op.req_wr)
         status_nxt[NUM_CH + int'(sel)] = setv;
      if (op.mode_wr)
         status_nxt[sel] = 1'b0;
      if (op.mclr || op.stat_rd)
         status_nxt[NUM_CH-1:0] = '0;
      status_nxt[NUM_CH-1:0] = status_nxt[NUM_CH-1:0] | tc_set;
   end

   always_comb begin
      mask_nxt = mask;
      if (op.onemask_wr) mask_nxt[sel] = setv;
      if (op.mclr)       mask_nxt = '1;
      if (op.mask_clr)   mask_nxt = '0;
      if (op.mask_ld)    mask_nxt = wr_data[NUM_CH-1:0];
   end

   always_comb begin
      req_nxt = req;
      if (op.req_wr) req_nxt[sel] = setv;
   end

   always_comb begin
      ptr_nxt = ptr;
      if (op.word_wr || op.word_rd) ptr_nxt = ~ptr;
      if (op.ptr_clr || op.mclr)    ptr_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         command <= '0;
         mask    <= '1;
         req     <= '0;
         status  <= '0;
         temp    <= '0;
         ptr     <= 1'b0;
      end else begin
         status <= status_nxt;
         mask   <= mask_nxt;
         req    <= req_nxt;
         ptr    <= ptr_nxt;
         if (op.cmd_wr)  command <= wr_data;
         if (op.ptr_clr) temp    <= wr_data;
         if (op.mclr)    temp    <= '0;
      end
   end
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
   import dmac_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OFFS_W = 4,
   parameter int NUM_CH = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [OFFS_W-1:0]        reg_offset,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [NUM_CH-1:0]        tc_set,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     ctl_enable,
   output logic [NUM_CH-1:0]        chan_req,
   output logic [NUM_CH-1:0]        chan_mask,
   output logic [NUM_CH*2*DATA_W-1:0] base_addr_flat,
   output logic [NUM_CH*2*DATA_W-1:0] base_cnt_flat,
   output logic [NUM_CH*DATA_W-1:0] mode_flat,
   output logic [DATA_W-1:0]        hold_byte
);
   localparam int WORD_W = 2 * DATA_W;
   localparam int CH_W   = $clog2(NUM_CH);
   localparam int STAT_W = 2 * NUM_CH;

   // Elaboration-time parameter checks
   if (DATA_W != 8) begin : g_bad_data
      $error("dmac_regfile: DATA_W must be 8");
   end
   if (NUM_CH != 4) begin : g_bad_ch
      $error("dmac_regfile: the offset map fixes NUM_CH at 4");
   end
   if (OFFS_W != 4) begin : g_bad_ofs
      $error("dmac_regfile: OFFS_W must be 4");
   end

   dmac_op_t            op;
   logic [DATA_W-1:0]   command;
   logic [STAT_W-1:0]   status;
   logic                ptr;
   logic [CH_W-1:0]     word_ch;
   logic [CH_W-1:0]     data_ch;

   logic [WORD_W-1:0]   cur_addr [NUM_CH];
   logic [WORD_W-1:0]   cur_cnt  [NUM_CH];

   assign word_ch = reg_offset[CH_W:1];
   assign data_ch = wr_data[CH_W-1:0];

   dmac_decode #(.OFFS_W(OFFS_W), .NUM_CH(NUM_CH)) u_dec (
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .reg_offset (reg_offset),
      .op         (op)
   );

   dmac_global_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_glob (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .wr_data (wr_data),
      .tc_set  (tc_set),
      .command (command),
      .mask    (chan_mask),
      .req     (chan_req),
      .status  (status),
      .temp    (hold_byte),
      .ptr     (ptr)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit_word;
      assign hit_word = op.word_wr && (word_ch == CH_W'(i));

      dmac_chan_regs #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_ch (
         .clk       (clk),
         .rst       (rst),
         .addr_we   (hit_word && !op.word_cnt),
         .cnt_we    (hit_word &&  op.word_cnt),
         .mode_we   (op.mode_wr && (data_ch == CH_W'(i))),
         .lane_hi   (ptr),
         .wr_data   (wr_data),
         .base_addr (base_addr_flat[i*WORD_W +: WORD_W]),
         .cur_addr  (cur_addr[i]),
         .base_cnt  (base_cnt_flat[i*WORD_W +: WORD_W]),
         .cur_cnt   (cur_cnt[i]),
         .mode      (mode_flat[i*DATA_W +: DATA_W])
      );
   end

   assign ctl_enable = ~command[DIS_BIT];

   // Read path: combinational, side effects applied at the next edge
   logic [WORD_W-1:0] rd_word;
   always_comb begin
      rd_word = op.word_cnt ? cur_cnt[word_ch] : cur_addr[word_ch];
      rd_data = '0;
      if (op.stat_rd)
         rd_data = status;
      else if (op.word_rd)
         rd_data = ptr ? rd_word[WORD_W-1:DATA_W] : rd_word[DATA_W-1:0];
   end

endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk
   import dmac_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OFFS_W = 4,
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              rd_en,
   input logic [OFFS_W-1:0] reg_offset,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              ctl_enable,
   input logic [NUM_CH-1:0] chan_req,
   input logic [NUM_CH-1:0] chan_mask
);
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (chan_mask == '1 && chan_req == '0 && ctl_enable));

   a_r4_enable_inverse: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_offset[3:0] == OFS_CMD) |=> (ctl_enable == !$past(wr_data[DIS_BIT])));

   a_r5_request_follows: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_offset[3:0] == OFS_SWREQ)
      |=> (chan_req[$past(wr_data[1:0])] == $past(wr_data[SETCLR_BIT])));

   a_r6_single_mask: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_offset[3:0] == OFS_ONEMASK)
      |=> (chan_mask[$past(wr_data[1:0])] == $past(wr_data[SETCLR_BIT])));

   a_r8_mclr_masks_all: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_offset[3:0] == OFS_MCLR) |=> (chan_mask == '1));

   a_r9_mask_clear_all: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_offset[3:0] == OFS_MASKCLR) |=> (chan_mask == '0));

   a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
      !rd_en |-> (rd_data == '0));

   a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
      (wr_en && rd_en) |-> (rd_data == '0));
endmodule

bind dmac_regfile dmac_regfile_chk #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .reg_offset (reg_offset),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .ctl_enable (ctl_enable),
   .chan_req   (chan_req),
   .chan_mask  (chan_mask)
);

// File: tb/dmac_regfile_test.sv
module dmac_regfile_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  reg_offset = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  tc_set = '0;
   logic [7:0]  rd_data;
   logic        ctl_enable;
   logic [3:0]  chan_req;
   logic [3:0]  chan_mask;
   logic [63:0] base_addr_flat;
   logic [63:0] base_cnt_flat;
   logic [31:0] mode_flat;
   logic [7:0]  hold_byte;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   dmac_regfile uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_offset(reg_offset),
      .wr_data(wr_data), .tc_set(tc_set), .rd_data(rd_data), .ctl_enable(ctl_enable),
      .chan_req(chan_req), .chan_mask(chan_mask), .base_addr_flat(base_addr_flat),
      .base_cnt_flat(base_cnt_flat), .mode_flat(mode_flat), .hold_byte(hold_byte)
   );

   typedef enum {K_RD, K_EN, K_REQ, K_MASK, K_MODE, K_BADDR, K_BCNT, K_HOLD} kind_e;
   typedef struct {
      kind_e       k;
      logic [63:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];

   function automatic logic [63:0] observe(input kind_e k);
      case (k)
         K_RD:    return {56'd0, rd_data};
         K_EN:    return {63'd0, ctl_enable};
         K_REQ:   return {60'd0, chan_req};
         K_MASK:  return {60'd0, chan_mask};
         K_MODE:  return {32'd0, mode_flat};
         K_BADDR: return base_addr_flat;
         K_BCNT:  return base_cnt_flat;
         default: return {56'd0, hold_byte};
      endcase
   endfunction

   // Monitor: compares queued expectations mid-cycle, away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it  = sb.pop_front();
            act = observe(it.k);
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_at(input kind_e k, input logic [63:0] e, input string tag);
      item_t it;
      it.k = k; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; rd_en = 1'b0; tc_set = '0; wr_data = '0; reg_offset = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; reg_offset = a; wr_data = d;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      rd_en = 1'b1; reg_offset = a;
      expect_at(K_RD, {56'd0, e}, tag);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic tc(input logic [3:0] m);
      tc_set = m;
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      expect_at(K_EN,    64'd1, "R1 enable after reset");
      expect_at(K_MASK,  64'hF, "R1 mask after reset");
      expect_at(K_REQ,   64'd0, "R1 request after reset");
      expect_at(K_BADDR, 64'd0, "R1 addresses after reset");
      expect_at(K_BCNT,  64'd0, "R1 counts after reset");
      expect_at(K_MODE,  64'd0, "R1 modes after reset");
      expect_at(K_HOLD,  64'd0, "R1 holding byte after reset");
      rd(4'd8, 8'h00, "R1 status after reset");

      // R2/R3: ch0 address as low then high byte
      wr(4'd0, 8'h34);
      wr(4'd0, 8'h12);
      expect_at(K_BADDR, 64'h0000_0000_0000_1234, "R2 ch0 address load");
      rd(4'd0, 8'h34, "R11 ch0 address low byte");
      rd(4'd0, 8'h12, "R3 read toggled pointer to high byte");

      // R2: ch3 count on odd offset
      wr(4'd7, 8'hCD);
      wr(4'd7, 8'hAB);
      expect_at(K_BCNT, 64'hABCD_0000_0000_0000, "R2 ch3 count load");

      // R3: pointer clear via offset 12, holding byte latch
      wr(4'd2, 8'h55);
      wr(4'd12, 8'h3C);
      expect_at(K_HOLD, 64'h3C, "R3 holding byte latch");
      wr(4'd2, 8'h66);
      expect_at(K_BADDR, 64'h0000_0000_0066_1234, "R3 pointer cleared before low write");
      wr(4'd2, 8'h77);
      wr(4'd2, 8'h88);
      expect_at(K_BADDR, 64'h0000_0000_7788_1234, "R2 low write keeps high half");
      wr(4'd12, 8'h00);

      // R4: command disable bit
      wr(4'd8, 8'h04);
      expect_at(K_EN, 64'd0, "R4 disable bit set");
      wr(4'd8, 8'hFB);
      expect_at(K_EN, 64'd1, "R4 other command bits leave enable high");
      wr(4'd8, 8'h00);

      // R5: software request set and clear with status bit 4+ch
      wr(4'd9, 8'h06);
      expect_at(K_REQ, 64'h4, "R5 request ch2 set");
      rd(4'd8, 8'h40, "R5 status request bit ch2");
      wr(4'd9, 8'h02);
      expect_at(K_REQ, 64'h0, "R5 request ch2 cleared");
      rd(4'd8, 8'h00, "R5 status request bit cleared");

      // R7/R10: terminal count, mode write clears its channel's bit
      tc(4'b1010);
      wr(4'd11, 8'h47);
      expect_at(K_MODE, 64'h4700_0000, "R7 ch3 mode stored");
      rd(4'd8, 8'h02, "R7 mode write cleared status bit 3");
      rd(4'd8, 8'h00, "R10 status read cleared low bits");

      // R6/R9: mask operations
      wr(4'd10, 8'h01);
      expect_at(K_MASK, 64'hD, "R6 unmask ch1 only");
      wr(4'd10, 8'h05);
      expect_at(K_MASK, 64'hF, "R6 mask ch1 again");
      wr(4'd14, 8'h00);
      expect_at(K_MASK, 64'h0, "R9 clear all masks");
      wr(4'd15, 8'hA5);
      expect_at(K_MASK, 64'h5, "R9 load mask from low bits");

      // R8: master clear
      wr(4'd9, 8'h05);
      tc(4'b0001);
      wr(4'd8, 8'h04);
      wr(4'd0, 8'h99);
      wr(4'd13, 8'h00);
      expect_at(K_MASK, 64'hF, "R8 master clear masks all");
      expect_at(K_REQ,  64'h2, "R8 master clear keeps request");
      expect_at(K_EN,   64'd0, "R8 master clear keeps command");
      expect_at(K_HOLD, 64'd0, "R8 master clear zeroes holding byte");
      wr(4'd0, 8'hAA);
      expect_at(K_BADDR, 64'h0000_0000_7788_12AA, "R8 master clear reset pointer");
      rd(4'd8, 8'h20, "R8 status low bits cleared, high kept");
      wr(4'd8, 8'h00);
      wr(4'd12, 8'h00);

      // R11: reads of unused offsets return 0 and do not move the pointer
      rd(4'd9,  8'h00, "R11 offset 9 reads zero");
      rd(4'd15, 8'h00, "R11 offset 15 reads zero");
      rd(4'd12, 8'h00, "R11 offset 12 reads zero");
      rd(4'd0,  8'hAA, "R11 pointer unmoved by other reads");
      rd(4'd1,  8'h00, "R11 ch0 count high byte");
      reg_offset = 4'd0;
      expect_at(K_RD, 64'd0, "R11 rd_data zero with rd_en low");
      @(negedge clk);

      // R10: pulse and read-clear in the same cycle
      rd_en = 1'b1; reg_offset = 4'd8; tc_set = 4'b0001;
      expect_at(K_RD, 64'h20, "R10 status read during pulse");
      @(negedge clk);
      idle_inputs();
      rd(4'd8, 8'h21, "R10 pulse wins over read clear");
      rd(4'd8, 8'h20, "R10 read clears low bits");

      // R12: write and read together
      wr_en = 1'b1; rd_en = 1'b1; reg_offset = 4'd0; wr_data = 8'h11;
      expect_at(K_RD, 64'd0, "R12 rd_data zero on collision");
      @(negedge clk);
      idle_inputs();
      expect_at(K_BADDR, 64'h0000_0000_7788_1211, "R12 write applied");
      rd(4'd0, 8'h12, "R12 read side effect suppressed");

      @(negedge clk);
      #2;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule